// File: doc/BRIEF.md
# Modem Status Tracker with Loopback

This block holds the modem control bits of a serial port and derives from them the modem status byte. It keeps sticky change flags that record how the status moved between control writes. A control write keeps five bits. One of them selects a self-test path in which the four control outputs are fed back as the four status inputs. With that path off, the status reports carrier-detect and data-set-ready as active and the other two lines as idle, so software that waits on those lines does not block.

Each control write compares the new live status with the previous one. A change on clear-to-send, data-set-ready or carrier-detect raises its change flag. The ring change flag rises only when ring-indicator falls. The flags stay set until the status byte is read. A read strobe returns the whole byte in the same cycle, and the flags are clear from the next cycle on. A single-bit summary of the flags feeds the port's interrupt identification logic.

Top module: `msl_modem_status`

## Requirements
- R1: A control write stores bits 4:0 of the write data in the control register, which is visible on `ctl_q`; data bits 7:5 have no effect. Bit 4 is loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS, bit 0 DTR.
- R2: With loopback set, status bit 4 (CTS) follows RTS, bit 5 (DSR) follows DTR, bit 6 (RI) follows OUT1 and bit 7 (DCD) follows OUT2, from the cycle after the write.
- R3: With loopback clear, status bits 7:4 read 4'b1010 (DCD and DSR high, RI and CTS low).
- R4: On a control write, a change of CTS, DSR or DCD against the previous status sets status bit 0, 1 or 3 respectively.
- R5: Status bit 2 is set by a control write only when RI goes from 1 to 0; a rise of RI leaves it unchanged.
- R6: Status bits 3:0 are sticky: writes that cause no change, and idle cycles, keep them, and writes only add flags.
- R7: A read strobe leaves the presented byte unchanged in its own cycle; from the next cycle bits 3:0 are clear and bits 7:4 are unchanged.
- R8: When a read strobe and a control write fall in the same cycle, flags that existed before are cleared and flags raised by that write are kept.
- R9: After reset the control register holds the reset value (default 0), status bits 7:4 are the live status derived from it (0xA0 for the default) and bits 3:0 are clear.
- R10: `any_delta` is high exactly when some status bit 3:0 is set, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control write data (bits 4:0 used) |
| stat_rd_en | input | 1 | Status read strobe; clears change flags after this cycle |
| ctl_q | output | 5 | Stored control bits |
| stat_q | output | 8 | Status byte: live lines in 7:4, change flags in 3:0 |
| any_delta | output | 1 | OR of the change flags |

## Verification
Stimulus walks each control bit on and off in loopback, so each line's mapping and its change flag are exercised alone, and RI is toggled both ways to separate the falling-edge rule from a plain change rule. Switches between loopback and normal mode with differing line states raise several flags in one write. Writes with junk in bits 7:5 show that those bits are dropped. Reads are placed alone, next to writes and in the same cycle as writes, which shows clearing order and stickiness apart. A long pseudo-random stretch of mixed writes and reads is then compared with a behavioural model on every clock.

// File: rtl/msl_pkg.sv
package msl_pkg;

    localparam int CTL_W  = 5;
    localparam int STAT_W = 8;
    localparam int FLAG_W = 4;

    // Control bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    // Live status lines, packed in status bit order 7..4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } live_t;

    // Change flags, packed in status bit order 3..0
    typedef struct packed {
        logic d_dcd;
        logic te_ri;
        logic d_dsr;
        logic d_cts;
    } flag_t;

    function automatic live_t map_live(input logic [CTL_W-1:0] ctl);
        live_t l;
        if (ctl[CB_LOOP]) begin
            l.cts = ctl[CB_RTS];
            l.dsr = ctl[CB_DTR];
            l.ri  = ctl[CB_OUT1];
            l.dcd = ctl[CB_OUT2];
        end else begin
            l.cts = 1'b0;
            l.dsr = 1'b1;
            l.ri  = 1'b0;
            l.dcd = 1'b1;
        end
        return l;
    endfunction

endpackage

// File: rtl/msl_ctrl_reg.sv
module msl_ctrl_reg
    import msl_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [CTL_W-1:0]  RESET_CTL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CTL_W-1:0]  ctl_d,
    output logic [CTL_W-1:0]  ctl_q
);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } creg_t;

    creg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.ctl = wr_data[CTL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ctl <= RESET_CTL;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_d = s_d.ctl;
    assign ctl_q = s_q.ctl;

    // R1: the stored bits only move on a write
    p_ctl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q));

endmodule

// File: rtl/msl_live_map.sv
module msl_live_map
    import msl_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output live_t            live
);

    always_comb begin
        live = map_live(ctl);
    end

endmodule

// File: rtl/msl_flag_track.sv
module msl_flag_track
    import msl_pkg::*;
#(
    parameter logic [CTL_W-1:0] RESET_CTL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             loop_q,
    input  live_t            live_next,
    output logic [STAT_W-1:0] stat_q,
    output logic             any_q
);

    localparam live_t LIVE_RST = map_live(RESET_CTL);

    typedef struct packed {
        live_t live;
        flag_t flag;
        logic  any;
    } trk_t;

    trk_t  s_d, s_q;
    flag_t raised;

    always_comb begin
        raised = '0;
        if (wr_en) begin
            raised.d_cts = live_next.cts ^ s_q.live.cts;
            raised.d_dsr = live_next.dsr ^ s_q.live.dsr;
            raised.d_dcd = live_next.dcd ^ s_q.live.dcd;
            raised.te_ri = s_q.live.ri & ~live_next.ri;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.live = live_next;
        if (rd_en) begin
            s_d.flag = '0;
        end
        s_d.flag = s_d.flag | raised;
        s_d.any  = |s_d.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.live <= LIVE_RST;
            s_q.flag <= '0;
            s_q.any  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_q = {s_q.live, s_q.flag};
    assign any_q  = s_q.any;

    // R10: registered summary agrees with the flag field
    p_any_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_q == (stat_q[3:0] != 4'h0));

    // R6: with no write and no read the flags hold
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> $stable(stat_q[3:0]));

    // R7: a read alone empties the flags for the next cycle
    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (stat_q[3:0] == 4'h0));

    // R5: the ring flag only rises on a falling ring line
    p_ri_trailing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> ($past(stat_q[6]) && !stat_q[6]));

    // R3: outside loopback the live lines are fixed
    p_normal_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_q |-> (stat_q[7:4] == 4'b1010));

endmodule

// File: rtl/msl_modem_status.sv
module msl_modem_status
    import msl_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter logic [CTL_W-1:0] RESET_CTL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [DATA_W-1:0] ctl_wr_data,
    input  logic              stat_rd_en,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              any_delta
);

    logic [CTL_W-1:0] ctl_next;
    live_t            live_next;

    msl_ctrl_reg #(
        .DATA_W    (DATA_W),
        .RESET_CTL (RESET_CTL)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ctl_d   (ctl_next),
        .ctl_q   (ctl_q)
    );

    msl_live_map u_map (
        .ctl  (ctl_next),
        .live (live_next)
    );

    msl_flag_track #(
        .RESET_CTL (RESET_CTL)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr_en),
        .rd_en     (stat_rd_en),
        .loop_q    (ctl_q[CB_LOOP]),
        .live_next (live_next),
        .stat_q    (stat_q),
        .any_q     (any_delta)
    );

    // R2: in loopback the status lines mirror the stored control bits
    p_loop_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CB_LOOP] |-> (stat_q[7:4] ==
            {ctl_q[CB_OUT2], ctl_q[CB_OUT1], ctl_q[CB_DTR], ctl_q[CB_RTS]}));

endmodule

// File: tb/msl_modem_status_bench.sv
module msl_modem_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = '0;
    logic       stat_rd_en = 1'b0;
    logic [4:0] ctl_q;
    logic [7:0] stat_q;
    logic       any_delta;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    int m_ctl;
    int m_hi;
    int m_flags;

    always #5 clk = ~clk;

    msl_modem_status u_msl_modem_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .stat_rd_en  (stat_rd_en),
        .ctl_q       (ctl_q),
        .stat_q      (stat_q),
        .any_delta   (any_delta)
    );

    function automatic int lines_of(input int c);
        if ((c & 16) != 0)
            return (((c >> 3) & 1) * 8) + (((c >> 2) & 1) * 4) +
                   ((c & 1) * 2) + ((c >> 1) & 1);
        return 10;
    endfunction

    task automatic check(input string tag);
        int exp_stat;
        exp_stat = m_hi * 16 + m_flags;
        n_cmp++;
        if (ctl_q !== 5'(m_ctl)) begin
            n_bad++;
            $display("FAIL %s ctl_q actual=%h expected=%h", tag, ctl_q, m_ctl);
        end
        n_cmp++;
        if (stat_q !== 8'(exp_stat)) begin
            n_bad++;
            $display("FAIL %s stat_q actual=%h expected=%h", tag, stat_q, exp_stat);
        end
        n_cmp++;
        if (any_delta !== (m_flags != 0)) begin
            n_bad++;
            $display("FAIL R10 (%s) any_delta actual=%b expected=%b", tag, any_delta, m_flags != 0);
        end
    endtask

    // drive at a falling edge, advance the model at the rising edge, compare at the next falling edge
    task automatic step(input bit w, input int d, input bit r, input string tag);
        int nc, nh, nf, oh;
        ctl_wr_en   = w;
        ctl_wr_data = 8'(d);
        stat_rd_en  = r;
        @(posedge clk);
        oh = m_hi;
        nc = w ? (d & 31) : m_ctl;
        nh = lines_of(nc);
        nf = r ? 0 : m_flags;
        if (w) begin
            if (((oh ^ nh) & 1) != 0) nf |= 1;
            if (((oh ^ nh) & 2) != 0) nf |= 2;
            if (((oh ^ nh) & 8) != 0) nf |= 8;
            if ((oh & 4) != 0 && (nh & 4) == 0) nf |= 4;
        end
        m_ctl = nc; m_hi = nh; m_flags = nf;
        @(negedge clk);
        check(tag);
        ctl_wr_en  = 1'b0;
        stat_rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int lf;
        m_ctl = 0; m_hi = 10; m_flags = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9 reset");
        // R9 idle after reset: nothing moves
        step(0, 0, 0, "R9 idle");
        // R2 R3 R4 enter loopback with all lines low: DSR and DCD flags
        step(1, 'h10, 0, "R2 R4 enter loop");
        // R7 read: byte shown, then flags cleared
        step(0, 0, 1, "R7 read");
        // R2 walk each control bit; R5 RI rise gives no flag
        step(1, 'h11, 0, "R2 DTR->DSR");
        step(1, 'h13, 0, "R2 RTS->CTS");
        step(1, 'h17, 0, "R5 RI rise");
        step(1, 'h1F, 0, "R2 OUT2->DCD");
        // R6 same value rewritten keeps flags, no new ones
        step(1, 'h1F, 0, "R6 rewrite");
        step(0, 0, 0, "R6 idle");
        step(0, 0, 1, "R7 read2");
        // R5 RI fall sets bit 2
        step(1, 'h1B, 0, "R5 RI fall");
        // R1 junk in upper bits ignored
        step(1, 'hFB, 0, "R1 upper bits");
        step(1, 'hE0, 0, "R1 R3 leave loop");
        // R8 read and write together
        step(1, 'h16, 1, "R8 rd+wr");
        step(0, 0, 0, "R8 after");
        step(1, 'h12, 1, "R8 rd+wr RI fall");
        step(0, 0, 1, "R7 read3");
        // R4 R6 R10 pseudo-random mix
        lf = 'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = ((lf >> 1) ^ ((lf & 1) ? 'hB400 : 0)) & 'hFFFF;
            step((lf & 3) != 0, (lf >> 4) & 255, ((lf >> 12) & 3) == 0, "R4 R6 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule